// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This unit multiplies two 32-bit words element by element, treating each word as a vector of 8-bit elements. It adds the products together, adds a 32-bit accumulator operand to that total, and returns one 32-bit result. Each operation is issued with a valid strobe. The result comes back two clock cycles later with its own valid strobe, and a new operation can be issued on every cycle.

Per-operation controls:

- **Element count.** A mode bit picks two elements or four elements per vector.
- **Half select.** In two-element mode, a select bit picks which 16-bit half of each word supplies the elements.
- **Signedness.** A sign-mode bit treats both vectors as unsigned. It can instead treat the first vector's bytes as signed while the second stays unsigned.
- **Accumulator negate.** The accumulator can be negated before it is added.
- **Saturation.** A saturate flag clamps the final sum instead of letting it wrap.

Top module: `dot8_acc_unit`

## Requirements
- R1: `res_valid` is high exactly two clock cycles after a cycle in which `in_valid` was high, and low two cycles after a cycle in which `in_valid` was low.
- R2: With `in_quad`=1 and `in_mixed`=0, res = sum over k=0..3 of a_k*b_k + in_acc (mod 2^32), where byte k is bits [8k+7:8k] and all bytes are unsigned.
- R3: With `in_mixed`=1, bytes of `in_a` are two's-complement signed, bytes of `in_b` are unsigned, and `in_acc` is read as a signed 32-bit value; with `in_mixed`=0 `in_acc` is unsigned.
- R4: With `in_quad`=0 and `in_hi_half`=0, only bytes 0 and 1 of each word contribute; bytes 2 and 3 have no effect on the result.
- R5: With `in_quad`=0 and `in_hi_half`=1, only bytes 2 and 3 of each word contribute; bytes 0 and 1 have no effect.
- R6: With `in_quad`=1, `in_hi_half` has no effect on the result.
- R7: With `in_acc_neg`=1 the accumulator is negated before the addition.
- R8: With `in_sat`=1 and `in_mixed`=1, the exact sum is clamped to [0x80000000, 0x7FFFFFFF] read as signed.
- R9: With `in_sat`=1 and `in_mixed`=0, the exact sum is clamped to [0, 0xFFFFFFFF]; a negative sum gives 0.
- R10: With `in_sat`=0 the result is the exact sum modulo 2^32.
- R11: During and right after synchronous reset (`rst`=1), `res_valid` is 0 and `res` is 0.
- R12: `res` keeps its last value on every cycle in which `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| in_a | input | 32 | First packed byte vector |
| in_b | input | 32 | Second packed byte vector (always unsigned) |
| in_acc | input | 32 | Accumulator operand |
| in_mixed | input | 1 | 0: all unsigned; 1: `in_a` bytes and `in_acc` signed |
| in_hi_half | input | 1 | Two-element mode: 0 low half, 1 high half |
| in_quad | input | 1 | 0: two elements; 1: four elements |
| in_acc_neg | input | 1 | Negate accumulator before adding |
| in_sat | input | 1 | Clamp instead of wrap |
| res_valid | output | 1 | Result strobe |
| res | output | 32 | Result |

## Verification
Small ascending byte values with a modest accumulator check the basic lane pairing. Words full of 0x80 and 0xFF bytes separate signed from unsigned interpretation of `in_a` and `in_acc`. Two-element operations carry distinct junk in the unused half, so a wrong half select or a leaking upper lane changes the answer. The same quad operation is issued with both half-select values to show that the select does nothing there. Accumulators at the edges of both ranges, with and without negation and saturation, separate clamping from wrapping in each sign mode. A stream of pseudo-random operations with idle gaps exercises back-to-back issue, the latency and the holding of the result between valid outputs.

// File: rtl/dot8_pkg.sv
package dot8_pkg;

    localparam int DEF_ELEM_W = 8;
    localparam int DEF_LANES  = 4;

    typedef enum logic {
        SGN_UNSIGNED = 1'b0,
        SGN_MIXED    = 1'b1
    } sign_mode_e;

    // Byte lane feeding multiplier g: all lanes in quad mode, otherwise
    // the lower or upper half of the word selected by hi.
    function automatic int src_lane(input int g, input int lanes,
                                    input logic quad, input logic hi);
        if (quad)
            return g;
        return hi ? g + lanes / 2 : g;
    endfunction

endpackage

// File: rtl/dot8_lanes.sv
module dot8_lanes
    import dot8_pkg::*;
#(
    parameter int ELEM_W = DEF_ELEM_W,
    parameter int LANES  = DEF_LANES,
    localparam int WORD_W = ELEM_W * LANES,
    localparam int PROD_W = 2 * ELEM_W + 2,
    localparam int DOT_W  = PROD_W + $clog2(LANES)
) (
    input  logic [WORD_W-1:0]       a,
    input  logic [WORD_W-1:0]       b,
    input  sign_mode_e              mode,
    input  logic                    quad,
    input  logic                    hi,
    output logic signed [DOT_W-1:0] dot
);
    localparam int HALF = LANES / 2;

    logic signed [PROD_W-1:0] prod [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic                     en;
        logic [ELEM_W-1:0]        ea, eb;
        logic signed [ELEM_W:0]   sa, sb;
        logic signed [PROD_W-1:0] xa, xb;
        always_comb begin
            int idx;
            en  = quad || (g < HALF);
            idx = en ? src_lane(g, LANES, quad, hi) : 0;
            ea  = a[idx*ELEM_W +: ELEM_W];
            eb  = b[idx*ELEM_W +: ELEM_W];
            sa  = {(mode == SGN_MIXED) & ea[ELEM_W-1], ea};
            sb  = {1'b0, eb};
            xa  = PROD_W'(sa);
            xb  = PROD_W'(sb);
            prod[g] = en ? xa * xb : '0;
        end
        // R4: lanes beyond the selected half contribute nothing in pair mode
        if (g >= HALF) begin : g_upper
            always_comb begin
                if (!quad)
                    assert_pair_lane_idle_R4: assert (prod[g] == '0);
            end
        end
    end

    always_comb begin
        dot = '0;
        for (int i = 0; i < LANES; i++)
            dot = dot + DOT_W'(prod[i]);
    end

endmodule

// File: rtl/dot8_acc_prep.sv
module dot8_acc_prep
    import dot8_pkg::*;
#(
    parameter int WORD_W = DEF_ELEM_W * DEF_LANES,
    localparam int WIDE_W = WORD_W + 2
) (
    input  logic [WORD_W-1:0]        acc,
    input  sign_mode_e               mode,
    input  logic                     neg,
    output logic signed [WIDE_W-1:0] acc_wide
);
    logic signed [WIDE_W-1:0] ext;

    always_comb begin
        ext      = {{(WIDE_W-WORD_W){(mode == SGN_MIXED) & acc[WORD_W-1]}}, acc};
        acc_wide = neg ? -ext : ext;
    end

endmodule

// File: rtl/dot8_clamp.sv
module dot8_clamp
    import dot8_pkg::*;
#(
    parameter int WORD_W = DEF_ELEM_W * DEF_LANES,
    localparam int WIDE_W = WORD_W + 2
) (
    input  logic signed [WIDE_W-1:0] sum,
    input  sign_mode_e               mode,
    input  logic                     sat,
    output logic [WORD_W-1:0]        out
);
    localparam logic signed [WIDE_W-1:0] SMAX =
        {{(WIDE_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic signed [WIDE_W-1:0] SMIN =
        {{(WIDE_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
    localparam logic signed [WIDE_W-1:0] UMAX =
        {{(WIDE_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

    always_comb begin
        out = sum[WORD_W-1:0];
        if (sat) begin
            if (mode == SGN_MIXED) begin
                if (sum > SMAX)      out = SMAX[WORD_W-1:0];
                else if (sum < SMIN) out = SMIN[WORD_W-1:0];
            end else begin
                if (sum < 0)         out = '0;
                else if (sum > UMAX) out = UMAX[WORD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dot8_acc_unit.sv
module dot8_acc_unit
    import dot8_pkg::*;
#(
    parameter int ELEM_W = DEF_ELEM_W,
    parameter int LANES  = DEF_LANES,
    localparam int WORD_W = ELEM_W * LANES,
    localparam int PROD_W = 2 * ELEM_W + 2,
    localparam int DOT_W  = PROD_W + $clog2(LANES),
    localparam int WIDE_W = WORD_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic [WORD_W-1:0] in_acc,
    input  logic              in_mixed,
    input  logic              in_hi_half,
    input  logic              in_quad,
    input  logic              in_acc_neg,
    input  logic              in_sat,
    output logic              res_valid,
    output logic [WORD_W-1:0] res
);
    typedef struct packed {
        logic                     vld;
        logic signed [DOT_W-1:0]  dot;
        logic signed [WIDE_W-1:0] acc;
        sign_mode_e               mode;
        logic                     sat;
    } stage1_t;

    sign_mode_e               mode_in;
    logic signed [DOT_W-1:0]  dot_c;
    logic signed [WIDE_W-1:0] acc_c;
    logic signed [WIDE_W-1:0] sum_c;
    logic [WORD_W-1:0]        out_c;
    stage1_t                  s1_q;

    assign mode_in = in_mixed ? SGN_MIXED : SGN_UNSIGNED;

    dot8_lanes #(.ELEM_W(ELEM_W), .LANES(LANES)) u_lanes (
        .a(in_a), .b(in_b), .mode(mode_in), .quad(in_quad),
        .hi(in_hi_half), .dot(dot_c)
    );

    dot8_acc_prep #(.WORD_W(WORD_W)) u_prep (
        .acc(in_acc), .mode(mode_in), .neg(in_acc_neg), .acc_wide(acc_c)
    );

    // Stage 1: products summed, accumulator aligned
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld  <= in_valid;
            s1_q.dot  <= dot_c;
            s1_q.acc  <= acc_c;
            s1_q.mode <= mode_in;
            s1_q.sat  <= in_sat;
        end
    end

    assign sum_c = WIDE_W'($signed(s1_q.dot)) + $signed(s1_q.acc);

    dot8_clamp #(.WORD_W(WORD_W)) u_clamp (
        .sum(sum_c), .mode(s1_q.mode), .sat(s1_q.sat), .out(out_c)
    );

    // Stage 2: final add, clamp, result register
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= s1_q.vld;
            if (s1_q.vld)
                res <= out_c;
        end
    end

    assert_issue_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 res_valid);
    assert_idle_latency_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !res_valid);
    assert_hold_result_R12: assert property (@(posedge clk) disable iff (rst)
        !s1_q.vld |=> $stable(res));
    assert_zero_vector_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_a == '0 && !in_acc_neg && !in_sat) |=> ##1 (res == $past(in_acc, 2)));
    assert_unsigned_floor_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sat && !in_mixed && in_acc_neg && in_b == '0 && in_acc != '0)
        |=> ##1 (res == '0));

endmodule

// File: tb/test_dot8_acc_unit.sv
`timescale 1ns/1ps
module test_dot8_acc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_mixed, in_hi_half, in_quad, in_acc_neg, in_sat;
    logic [31:0] in_a, in_b, in_acc;
    logic        res_valid;
    logic [31:0] res;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dot8_acc_unit i_dot8_acc_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_acc(in_acc), .in_mixed(in_mixed), .in_hi_half(in_hi_half),
        .in_quad(in_quad), .in_acc_neg(in_acc_neg), .in_sat(in_sat),
        .res_valid(res_valid), .res(res)
    );

    // Behavioural reference
    function automatic logic [31:0] model(input logic [31:0] a, b, acc,
                                          input logic mixed, hi, quad, neg, sat);
        longint dot = 0;
        longint accv, s;
        for (int k = 0; k < 4; k++) begin
            int idx;
            logic [7:0] ba, bb;
            longint ea, eb;
            if (!quad && k >= 2) continue;
            idx = quad ? k : (hi ? k + 2 : k);
            ba = a[8*idx +: 8];
            bb = b[8*idx +: 8];
            ea = mixed ? longint'($signed(ba)) : longint'(ba);
            eb = longint'(bb);
            dot += ea * eb;
        end
        accv = mixed ? longint'($signed(acc)) : longint'(acc);
        if (neg) accv = -accv;
        s = dot + accv;
        if (sat) begin
            if (mixed) begin
                if (s > 64'sd2147483647)  s = 64'sd2147483647;
                if (s < -64'sd2147483648) s = -64'sd2147483648;
            end else begin
                if (s < 0)                s = 0;
                if (s > 64'sd4294967295)  s = 64'sd4294967295;
            end
        end
        return s[31:0];
    endfunction

    logic        prev_v = 1'b0;
    logic [31:0] prev_r = '0;
    logic [31:0] held   = '0;
    string       prev_tag = "R11";

    task automatic check(input string tag, input logic [31:0] act, exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] a, b, acc,
                        input logic mixed, hi, quad, neg, sat, input string tag);
        logic [31:0] exp_r;
        in_valid = v; in_a = a; in_b = b; in_acc = acc; in_mixed = mixed;
        in_hi_half = hi; in_quad = quad; in_acc_neg = neg; in_sat = sat;
        @(negedge clk);
        // output now reflects the operation issued one step earlier
        check({prev_tag, "/R1 valid"}, {31'b0, res_valid}, {31'b0, prev_v});
        if (prev_v) begin
            exp_r = prev_r;
            held  = prev_r;
            check(prev_tag, res, exp_r);
        end else begin
            check({prev_tag, "/R12 hold"}, res, held);
        end
        prev_v   = v;
        prev_r   = model(a, b, acc, mixed, hi, quad, neg, sat);
        prev_tag = tag;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 32'hDEADBEEF, 32'h12345678, 32'h0BADF00D, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, tag);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 0; in_a = 0; in_b = 0; in_acc = 0; in_mixed = 0;
        in_hi_half = 0; in_quad = 0; in_acc_neg = 0; in_sat = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 valid", {31'b0, res_valid}, 32'd0);
        check("R11 res", res, 32'd0);
        rst = 1'b0;

        // R2 unsigned quad basics
        step(1, 32'h04030201, 32'h08070605, 32'd100, 0, 0, 1, 0, 0, "R2");
        step(1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd7,   0, 0, 1, 0, 0, "R2");
        step(1, 32'h0, 32'hFFFFFFFF, 32'hCAFEF00D,   0, 0, 1, 0, 0, "R2");
        // R3 mixed signedness
        step(1, 32'h80808080, 32'hFFFFFFFF, 32'd0,   1, 0, 1, 0, 0, "R3");
        step(1, 32'hFF01FF01, 32'h80808080, 32'hFFFFFFF0, 1, 0, 1, 0, 0, "R3");
        step(1, 32'h80808080, 32'hFFFFFFFF, 32'hFFFFFFF0, 0, 0, 1, 0, 0, "R3");
        // R4 / R5 pair mode with junk in the other half
        step(1, 32'hA5C30302, 32'h5A3C0504, 32'd1, 0, 0, 0, 0, 0, "R4");
        step(1, 32'h0000FF80, 32'h00000201, 32'd1, 1, 0, 0, 0, 0, "R4");
        step(1, 32'h0302A5C3, 32'h05045A3C, 32'd1, 0, 1, 0, 0, 0, "R5");
        step(1, 32'hFF800000, 32'h02010000, 32'd1, 1, 1, 0, 0, 0, "R5");
        // R6 quad ignores half select
        step(1, 32'h11223344, 32'h55667788, 32'd9, 1, 0, 1, 0, 0, "R6");
        step(1, 32'h11223344, 32'h55667788, 32'd9, 1, 1, 1, 0, 0, "R6");
        // R7 accumulator negate
        step(1, 32'h00000A0A, 32'h00000101, 32'd15, 0, 0, 0, 1, 0, "R7");
        step(1, 32'h00000A0A, 32'h00000101, 32'hFFFFFFFB, 1, 0, 0, 1, 0, "R7");
        // R8 signed saturation both ends
        step(1, 32'h7F7F7F7F, 32'hFFFFFFFF, 32'h7FFFFFF0, 1, 0, 1, 0, 1, "R8");
        step(1, 32'h80808080, 32'hFFFFFFFF, 32'h80000000, 1, 0, 1, 0, 1, "R8");
        step(1, 32'h00000001, 32'h00000001, 32'h80000000, 1, 0, 1, 1, 1, "R8");
        // R9 unsigned saturation both ends
        step(1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFF0, 0, 0, 1, 0, 1, "R9");
        step(1, 32'h00000003, 32'h00000002, 32'd5, 0, 0, 1, 1, 1, "R9");
        step(1, 32'h0, 32'h0, 32'h80000000, 0, 0, 0, 1, 1, "R9");
        // R10 wrap without saturation
        step(1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFF0, 0, 0, 1, 0, 0, "R10");
        step(1, 32'h7F7F7F7F, 32'hFFFFFFFF, 32'h7FFFFFF0, 1, 0, 1, 0, 0, "R10");
        step(1, 32'h00000003, 32'h00000002, 32'd5, 0, 0, 1, 1, 0, "R10");
        // R12 idle gap
        idle("R12"); idle("R12"); idle("R12");
        // R1 mixed traffic, pseudo-random operands
        for (int n = 0; n < 400; n++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(v, $urandom, $urandom, $urandom, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), "R1");
        end
        idle("R12"); idle("R12"); idle("R12");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule